// File: doc/BRIEF.md
# Masked Interrupt Controller With Halt Wake

This block gathers single-cycle request pulses from up to 32 peripheral sources for one CPU. Each pulse sets a sticky pending flag, and it does so whether or not that source is enabled. A level IRQ is raised toward the CPU whenever at least one pending source is also enabled and bit 0 of the global gate register is set. Software acknowledges an interrupt by writing ones to the pending register; each one clears the matching flag.

The CPU can put itself to sleep by writing the halt bit of the power register. The same condition that raises the IRQ (an enabled source pending while the global gate is open) ends the sleep. That condition also raises the IRQ on the same clock edge, so the CPU wakes straight into its interrupt handler.

The source bits are laid out as follows:

| Bits | Source |
|------|--------|
| 0 | vertical blank |
| 1 | horizontal blank |
| 2 | line compare |
| 3..6 | overflow of timers 0..3 |
| 8..11 | completion of copy channels 0..3 |
| 12 | keypad |
| 16 | inter-CPU sync |
| 17 | outbound mailbox empty |
| 18 | inbound mailbox holds data |
| 19 | card transfer done |

Top module: `irqc_top`

## Requirements
- R1: After reset, irq_o and halted_o are 0 and every register reads 0. Registers are selected by code: 0 is the global gate, 1 is the enable mask, 2 is the pending flags and 3 is the power register.
- R2: A pulse on src_req_i bit n sets pending bit n on that clock edge, even when enable bit n is 0. Bit 3 is timer 0 overflow, bit 0 is vertical blank and bit 12 is keypad.
- R3: On the edge after an enabled source becomes pending, irq_o is 1 only if bit 0 of the global gate is 1. A gate value of 0x2 keeps irq_o at 0.
- R4: A write to register 2 clears each pending bit whose data bit is 1 and whose byte lane enable is 1. All other pending bits keep their value.
- R5: When a request and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R6: irq_o is a registered level. It stays at 1 across idle cycles and across writes of zeros to register 2, until the last enabled pending bit is cleared.
- R7: A write to register 3 with byte lane 1 enabled and data bit 15 set to 1 sets halted_o. If lane 1 is off, or bit 15 is 0, the write has no effect. Register 3 reads back halted_o on bit 15 and 0 on all other bits.
- R8: An enabled source becoming pending while gate bit 0 is 1 clears halted_o and raises irq_o on the same edge. A masked request, or any request while the gate is 0, leaves halted_o set.
- R9: Writes to registers 0 and 1 update only the byte lanes whose reg_be_i bit is 1.
- R10: A halt write made while a qualifying interrupt is already pending leaves halted_o at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low synchronous reset |
| src_req_i | input | 32 | request pulses, one bit per source |
| reg_wr_i | input | 1 | register write strobe |
| reg_sel_i | input | 2 | register selected for the write |
| reg_wdata_i | input | 32 | write data |
| reg_be_i | input | 4 | byte lane enables for the write |
| rd_sel_i | input | 2 | register selected for readback |
| rd_data_o | output | 32 | readback data (combinational) |
| irq_o | output | 1 | level interrupt to the CPU |
| halted_o | output | 1 | CPU halt state |

## Verification
The bench latches a request while its source is masked. A design that dropped masked requests would then read 0 from the pending register and would never raise the IRQ once the mask is opened later. The bench also drives a request and an acknowledge on the same bit in the same cycle; a design that gave the clear priority would lose that event. It tries halt writes on the wrong byte lane and with bit 15 at 0, which a loose decoder would accept. It sends a masked request to a halted CPU, which a design keyed on raw pending rather than enabled pending would wrongly wake. Finally, it issues a halt write while an interrupt is already pending, where a design that let the halt write win would leave the CPU stuck asleep.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQ_W    = 32;
  localparam int LANE_N   = IRQ_W / 8;
  localparam int HALT_BIT = 15;

  typedef enum logic [1:0] {
    SEL_GATE    = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_PENDING = 2'd2,
    SEL_POWER   = 2'd3
  } irqc_sel_e;

  // expand byte enables into a bit mask
  function automatic logic [IRQ_W-1:0] lane_mask(input logic [LANE_N-1:0] be);
    logic [IRQ_W-1:0] m;
    for (int b = 0; b < LANE_N; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  // byte-lane merge of new data into an old value
  function automatic logic [IRQ_W-1:0] lane_merge(input logic [IRQ_W-1:0] old_v,
                                                  input logic [IRQ_W-1:0] new_v,
                                                  input logic [LANE_N-1:0] be);
    logic [IRQ_W-1:0] m;
    m = lane_mask(be);
    return (old_v & ~m) | (new_v & m);
  endfunction

  // pending update: clear selected ones, then set requests (request wins)
  function automatic logic [IRQ_W-1:0] pend_next(input logic [IRQ_W-1:0] cur,
                                                 input logic [IRQ_W-1:0] clr,
                                                 input logic [IRQ_W-1:0] req);
    return (cur & ~clr) | req;
  endfunction

  // the interrupt condition shared by the IRQ and the wake logic
  function automatic logic qualifies(input logic [IRQ_W-1:0] pend,
                                     input logic [IRQ_W-1:0] en,
                                     input logic             gate0);
    return (|(pend & en)) & gate0;
  endfunction
endpackage

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
  import irqc_pkg::*;
#(
  parameter int W  = IRQ_W,
  parameter int LN = LANE_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_wr_i,
  input  logic          en_wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [LN-1:0] be_i,
  output logic [W-1:0]  gate_q_o,
  output logic [W-1:0]  gate_d_o,
  output logic [W-1:0]  en_q_o,
  output logic [W-1:0]  en_d_o
);
  logic [W-1:0] gate_q, en_q;

  always_comb begin
    gate_d_o = gate_wr_i ? lane_merge(gate_q, wdata_i, be_i) : gate_q;
    en_d_o   = en_wr_i   ? lane_merge(en_q,   wdata_i, be_i) : en_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      gate_q <= '0;
      en_q   <= '0;
    end else begin
      gate_q <= gate_d_o;
      en_q   <= en_d_o;
    end
  end

  assign gate_q_o = gate_q;
  assign en_q_o   = en_q;
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
#(
  parameter int W = IRQ_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_q_o,
  output logic [W-1:0] pend_d_o
);
  logic [W-1:0] pend_q;

  assign pend_d_o = pend_next(pend_q, clr_i, req_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d_o;
  end

  assign pend_q_o = pend_q;
endmodule

// File: rtl/irqc_halt_irq.sv
module irqc_halt_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_req_i,
  input  logic qual_next_i,
  output logic irq_o,
  output logic halted_o
);
  logic irq_q, halt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      irq_q <= qual_next_i;
      if (qual_next_i)     halt_q <= 1'b0;
      else if (halt_req_i) halt_q <= 1'b1;
    end
  end

  assign irq_o    = irq_q;
  assign halted_o = halt_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IRQ_W-1:0]  src_req_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [IRQ_W-1:0]  reg_wdata_i,
  input  logic [LANE_N-1:0] reg_be_i,
  input  logic [1:0]        rd_sel_i,
  output logic [IRQ_W-1:0]  rd_data_o,
  output logic              irq_o,
  output logic              halted_o
);
  localparam int HALT_LANE = HALT_BIT / 8;

  logic              wr_gate, wr_en, wr_pend, halt_req, qual_next;
  logic [IRQ_W-1:0]  clr_mask;
  logic [IRQ_W-1:0]  gate_q, gate_d, en_q, en_d, pend_q, pend_d;

  assign wr_gate  = reg_wr_i && (reg_sel_i == SEL_GATE);
  assign wr_en    = reg_wr_i && (reg_sel_i == SEL_ENABLE);
  assign wr_pend  = reg_wr_i && (reg_sel_i == SEL_PENDING);
  assign halt_req = reg_wr_i && (reg_sel_i == SEL_POWER) &&
                    reg_be_i[HALT_LANE] && reg_wdata_i[HALT_BIT];
  assign clr_mask = wr_pend ? (reg_wdata_i & lane_mask(reg_be_i)) : '0;

  irqc_ctrl_regs u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gate_wr_i(wr_gate),
    .en_wr_i  (wr_en),
    .wdata_i  (reg_wdata_i),
    .be_i     (reg_be_i),
    .gate_q_o (gate_q),
    .gate_d_o (gate_d),
    .en_q_o   (en_q),
    .en_d_o   (en_d)
  );

  irqc_pending u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (src_req_i),
    .clr_i   (clr_mask),
    .pend_q_o(pend_q),
    .pend_d_o(pend_d)
  );

  assign qual_next = qualifies(pend_d, en_d, gate_d[0]);

  irqc_halt_irq u_hi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halt_req_i (halt_req),
    .qual_next_i(qual_next),
    .irq_o      (irq_o),
    .halted_o   (halted_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_sel_i)
      SEL_GATE:    rd_data_o = gate_q;
      SEL_ENABLE:  rd_data_o = en_q;
      SEL_PENDING: rd_data_o = pend_q;
      default:     rd_data_o[HALT_BIT] = halted_o;
    endcase
  end

  // R2
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_req_i) |=> ((pend_q & $past(src_req_i)) == $past(src_req_i)));

  // R4
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pend |=> ((pend_q & $past(clr_mask & ~src_req_i)) == '0));

  // R3
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((|(pend_q & en_q)) && gate_q[0]));

  // R6
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !reg_wr_i) |=> irq_o);

  // R8
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !halted_o);

  // R7
  halt_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> $past(halt_req));
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic        wr = 1'b0;
  logic [1:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [1:0]  rsel = '0;
  logic [31:0] rdata;
  logic        irq, halted;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(req), .reg_wr_i(wr),
    .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_be_i(be), .rd_sel_i(rsel),
    .rd_data_o(rdata), .irq_o(irq), .halted_o(halted)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rsel = s;
    #1;
    v = rdata;
  endtask

  task automatic wreg(input logic [1:0] s, input logic [31:0] d, input logic [3:0] b);
    wr = 1'b1; sel = s; wdata = d; be = b;
    tick();
    wr = 1'b0; be = '0;
  endtask

  task automatic pulse(input logic [31:0] r);
    req = r;
    tick();
    req = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R1 reg after reset", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 halted after reset", {31'b0, halted}, 32'h0);
  endtask

  task automatic t_masked_latch();
    logic [31:0] v;
    pulse(32'h0000_0008);
    rd(2, v);
    chk("R2 masked request latched", v, 32'h8);
    chk("R2 masked no irq", {31'b0, irq}, 32'h0);
    wreg(1, 32'h8, 4'hF);
    chk("R3 gate off no irq", {31'b0, irq}, 32'h0);
    wreg(0, 32'h2, 4'hF);
    chk("R3 gate bit1 no irq", {31'b0, irq}, 32'h0);
    wreg(0, 32'h1, 4'hF);
    chk("R3 gate bit0 irq", {31'b0, irq}, 32'h1);
    tick(); tick();
    chk("R6 irq held idle", {31'b0, irq}, 32'h1);
    wreg(2, 32'h0, 4'hF);
    chk("R6 irq held on zero clear", {31'b0, irq}, 32'h1);
    rd(2, v);
    chk("R4 zero write keeps pending", v, 32'h8);
    wreg(2, 32'h8, 4'hF);
    chk("R6 irq drops after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_lane_clear();
    logic [31:0] v;
    pulse(32'h0001_1001);
    wreg(2, 32'hFFFF_FFFF, 4'b0010);
    rd(2, v);
    chk("R4 lane-limited clear", v, 32'h0001_0001);
    wreg(2, 32'h0001_0000, 4'hF);
    rd(2, v);
    chk("R4 selective clear", v, 32'h0000_0001);
    wreg(2, 32'hFFFF_FFFF, 4'hF);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    pulse(32'h1);
    req = 32'h1; wr = 1'b1; sel = 2; wdata = 32'h1; be = 4'hF;
    tick();
    req = '0; wr = 1'b0; be = '0;
    rd(2, v);
    chk("R5 request beats clear", v, 32'h1);
    wreg(2, 32'hFFFF_FFFF, 4'hF);
  endtask

  task automatic t_lanes();
    logic [31:0] v;
    wreg(1, 32'hAABB_CCDD, 4'hF);
    wreg(1, 32'h1122_3344, 4'b0101);
    rd(1, v);
    chk("R9 enable lane merge", v, 32'hAA22_CC44);
    wreg(0, 32'hFFFF_FF00, 4'b1110);
    rd(0, v);
    chk("R9 gate lane merge", v, 32'hFFFF_FF01);
    wreg(0, 32'h1, 4'hF);
  endtask

  task automatic t_halt();
    logic [31:0] v;
    wreg(1, 32'h1, 4'hF);
    wreg(3, 32'h0000_8000, 4'b0001);
    chk("R7 wrong lane no halt", {31'b0, halted}, 32'h0);
    wreg(3, 32'h0000_7F00, 4'b0010);
    chk("R7 bit15 zero no halt", {31'b0, halted}, 32'h0);
    wreg(3, 32'h0000_8000, 4'b0010);
    chk("R7 halt entered", {31'b0, halted}, 32'h1);
    rd(3, v);
    chk("R7 power readback", v, 32'h0000_8000);
    pulse(32'h4);
    chk("R8 masked request keeps halt", {31'b0, halted}, 32'h1);
    chk("R8 masked request no irq", {31'b0, irq}, 32'h0);
    wreg(0, 32'h0, 4'hF);
    pulse(32'h1);
    chk("R8 gate closed keeps halt", {31'b0, halted}, 32'h1);
    wreg(2, 32'hFFFF_FFFF, 4'hF);
    wreg(0, 32'h1, 4'hF);
    pulse(32'h1);
    chk("R8 wake on qualifying", {31'b0, halted}, 32'h0);
    chk("R8 irq on wake", {31'b0, irq}, 32'h1);
    wreg(3, 32'h0000_8000, 4'b0010);
    chk("R10 halt refused while pending", {31'b0, halted}, 32'h0);
    wreg(2, 32'hFFFF_FFFF, 4'hF);
    chk("R6 irq low after final clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_masked_latch();
    t_lane_clear();
    t_collision();
    t_lanes();
    t_halt();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule